// File: doc/BRIEF.md
# SMBus Target Transmit PEC Sequencer

This block drives the byte sequence an SMBus target returns to a controller during a read. Software programs a byte count, a byte-control enable, a PEC enable and a reload flag. For every byte it needs from software, the block raises a one-cycle request, takes the byte and hands it to the shift engine. The shift engine reports each finished byte together with the controller's ACK or NACK.

With PEC insertion active, the programmed count covers the PEC byte as well as the data. Software is asked for one byte fewer than the count. If the controller ACKs the last software byte, the block presents its running CRC-8 as the final byte.

The CRC covers every byte on the bus since the most recent START or repeated START. That includes address and command bytes, which the bus logic reports on a separate receive strobe. Reload mode turns PEC insertion off, so every counted byte comes from software. Without byte control, the counter is unused and software bytes are requested until the controller NACKs.

Top module: `smbus_pec_tx_seq`

## Requirements
- R1: After reset `busy_o`, `tx_req_o`, `tx_valid_o` and `tx_is_pec_o` are all 0.
- R2: With `byte_ctl_en_i`=0, a software byte is requested after `go_i` and again after every ACKed byte, without limit. A NACK ends the transfer, and no PEC byte is ever sent.
- R3: With `byte_ctl_en_i`=1 and PEC inactive, exactly `nbytes_i` requests are raised. After the last byte is ACKed, `busy_o` falls and no extra byte is presented.
- R4: With `byte_ctl_en_i`=1, `pec_en_i`=1, `reload_i`=0 and `nbytes_i`=N≥1, exactly N−1 software requests are raised.
- R5: In the R4 configuration, once N−1 software bytes have been ACKed, the next byte is presented with `tx_is_pec_o`=1 and `tx_byte_o` equal to the current CRC. For N=1 this happens immediately after `go_i`. After that byte completes, `busy_o` falls.
- R6: With `reload_i`=1 the PEC enable has no effect: N requests are raised and no PEC byte follows.
- R7: The CRC is CRC-8 with polynomial x^8+x^2+x+1 (0x07), processed MSB first. It starts from 0 and is updated with each `rx_byte_i` on `rx_valid_i` and with each transmitted byte on `byte_done_i`.
- R8: A NACK (`ack_i`=0 with `byte_done_i`) ends the transfer in the next cycle. No further request or PEC byte follows.
- R9: `bus_start_i` resets the CRC to 0, so bytes seen before it do not affect the PEC.
- R10: `tx_req_o` is a single-cycle pulse. `nbytes_i`=0 with byte control on raises no request and sends no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start_i | input | 1 | START or repeated START seen; clears the CRC |
| rx_valid_i | input | 1 | A byte not sent by this block completed on the bus |
| rx_byte_i | input | 8 | That byte (address or command) |
| go_i | input | 1 | Begin a transmit phase; samples the configuration |
| nbytes_i | input | 8 | Programmed byte count |
| byte_ctl_en_i | input | 1 | Enables the byte counter and PEC insertion |
| pec_en_i | input | 1 | Count includes a PEC byte |
| reload_i | input | 1 | Reload mode; suppresses PEC insertion |
| tx_req_o | output | 1 | One-cycle request for a software byte |
| sw_valid_i | input | 1 | Software supplies a byte |
| sw_byte_i | input | 8 | Software byte |
| tx_valid_o | output | 1 | A byte is ready for the shift engine |
| tx_byte_o | output | 8 | Byte to shift out |
| tx_is_pec_o | output | 1 | Presented byte is the PEC |
| byte_done_i | input | 1 | Shift engine finished the presented byte |
| ack_i | input | 1 | Controller response to that byte (1 = ACK) |
| busy_o | output | 1 | Transmit phase in progress |

## Verification
The bench sweeps byte counts 0 to 4 over every combination of byte control, PEC enable and reload. Each combination is run with the controller NACKing at the first, second or third byte, or ACKing to the end. This tells apart the N, N−1 and unlimited request counts, and shows whether the PEC lands exactly at position N, including N=1. A NACK placed before, at and after the PEC slot shows that an early stop suppresses the PEC. Every run feeds a stray byte before START and an address byte after it, so the PEC value separates a correct CRC clear from a missing one.

// File: rtl/smbus_pec_tx_seq.sv
module smbus_pec_tx_seq #(
  parameter int CNT_W = 8,
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_start_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_byte_i,
  input  logic             go_i,
  input  logic [CNT_W-1:0] nbytes_i,
  input  logic             byte_ctl_en_i,
  input  logic             pec_en_i,
  input  logic             reload_i,
  output logic             tx_req_o,
  input  logic             sw_valid_i,
  input  logic [7:0]       sw_byte_i,
  output logic             tx_valid_o,
  output logic [7:0]       tx_byte_o,
  output logic             tx_is_pec_o,
  input  logic             byte_done_i,
  input  logic             ack_i,
  output logic             busy_o
);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_DATA, S_PEC} st_t;

  st_t              st_q;
  logic [CNT_W-1:0] left_q;
  logic             unlim_q, pec_q;
  logic [7:0]       data_q, crc_q;

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c ^ b;
    for (int i = 0; i < 8; i++)
      r = r[7] ? ((r << 1) ^ POLY) : (r << 1);
    return r;
  endfunction

  wire              pec_eff = byte_ctl_en_i & pec_en_i & ~reload_i;
  wire              n_zero  = (nbytes_i == '0);
  wire [CNT_W-1:0]  sw_cnt  = !byte_ctl_en_i ? '0 :
                              (pec_eff ? (n_zero ? '0 : nbytes_i - 1'b1) : nbytes_i);
  wire              accept  = sw_valid_i & ((st_q == S_REQ) | (st_q == S_WAIT));
  wire              fin     = byte_done_i & tx_valid_o;
  wire              more    = unlim_q | (left_q != '0);

  assign tx_req_o    = (st_q == S_REQ);
  assign tx_valid_o  = (st_q == S_DATA) | (st_q == S_PEC);
  assign tx_is_pec_o = (st_q == S_PEC);
  assign tx_byte_o   = (st_q == S_PEC) ? crc_q : data_q;
  assign busy_o      = (st_q != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      left_q  <= '0;
      unlim_q <= 1'b0;
      pec_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (go_i) begin
          left_q  <= sw_cnt;
          unlim_q <= ~byte_ctl_en_i;
          pec_q   <= pec_eff & ~n_zero;
          if (!byte_ctl_en_i || sw_cnt != '0) st_q <= S_REQ;
          else if (pec_eff && !n_zero)        st_q <= S_PEC;
        end
        S_REQ, S_WAIT: begin
          if (accept) begin
            data_q <= sw_byte_i;
            if (!unlim_q) left_q <= left_q - 1'b1;
            st_q <= S_DATA;
          end else begin
            st_q <= S_WAIT;
          end
        end
        S_DATA: if (byte_done_i) begin
          if (!ack_i)     st_q <= S_IDLE;
          else if (more)  st_q <= S_REQ;
          else if (pec_q) st_q <= S_PEC;
          else            st_q <= S_IDLE;
        end
        S_PEC: if (byte_done_i) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           crc_q <= '0;
    else if (bus_start_i) crc_q <= '0;
    else if (rx_valid_i)  crc_q <= crc_step(crc_q, rx_byte_i);
    else if (fin)         crc_q <= crc_step(crc_q, tx_byte_o);
  end

endmodule

module smbus_pec_tx_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_start_i,
  input logic       tx_req_o,
  input logic       tx_valid_o,
  input logic       tx_is_pec_o,
  input logic       byte_done_i,
  input logic       ack_i,
  input logic       busy_o,
  input logic [7:0] crc_q
);

  a_r10_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_o |=> !tx_req_o);

  a_r8_nack_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done_i && tx_valid_o && !ack_i) |=> !busy_o);

  a_r5_pec_after_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done_i && tx_is_pec_o) |=> !busy_o);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!tx_valid_o && !tx_req_o && !tx_is_pec_o));

  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start_i |=> (crc_q == 8'h00));

  a_r5_pec_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tx_is_pec_o |-> (tx_valid_o && !tx_req_o));

endmodule

bind smbus_pec_tx_seq smbus_pec_tx_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_start_i(bus_start_i), .tx_req_o(tx_req_o),
  .tx_valid_o(tx_valid_o), .tx_is_pec_o(tx_is_pec_o), .byte_done_i(byte_done_i),
  .ack_i(ack_i), .busy_o(busy_o), .crc_q(crc_q)
);

// File: tb/smbus_pec_tx_seq_tb.sv
module smbus_pec_tx_seq_tb_top;
  logic clk = 0, rst_n = 0;
  logic bus_start_i = 0, rx_valid_i = 0, go_i = 0;
  logic [7:0] rx_byte_i = 0, nbytes_i = 0, sw_byte_i = 0;
  logic byte_ctl_en_i = 0, pec_en_i = 0, reload_i = 0;
  logic sw_valid_i = 0, byte_done_i = 0, ack_i = 0;
  logic tx_req_o, tx_valid_o, tx_is_pec_o, busy_o;
  logic [7:0] tx_byte_o;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  smbus_pec_tx_seq dut_i (.*);

  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r = c;
    for (int k = 7; k >= 0; k--) begin
      logic fb = r[7] ^ b[k];
      r = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input bit bce, input bit pe, input bit rel, input int n,
                     input int nack_at, input int seed);
    int sw_need, exp_req, reqs = 0, nbyte = 0, pec_seen = 0, pec_val = -1;
    bit pec_slot, exp_pec, done = 0, hang = 1;
    logic [7:0] crc = 0;
    string tag;
    pec_slot = bce && pe && !rel && n != 0;
    sw_need  = !bce ? 1000 : ((pe && !rel) ? (n == 0 ? 0 : n - 1) : n);
    exp_req  = (sw_need < nack_at + 1) ? sw_need : nack_at + 1;
    exp_pec  = pec_slot && nack_at >= sw_need;
    tag = !bce ? "R2" : (rel ? "R6" : (pe ? "R4" : (n == 0 ? "R10" : "R3")));
    @(negedge clk);
    rx_valid_i = 1; rx_byte_i = 8'hA5 ^ seed[7:0];
    @(negedge clk); rx_valid_i = 0; bus_start_i = 1;
    @(negedge clk); bus_start_i = 0; rx_valid_i = 1; rx_byte_i = 8'h6B;
    crc = ref_crc(8'h00, 8'h6B);
    @(negedge clk); rx_valid_i = 0;
    nbytes_i = n[7:0]; byte_ctl_en_i = bce; pec_en_i = pe; reload_i = rel; go_i = 1;
    @(negedge clk); go_i = 0;
    for (int cyc = 0; cyc < 200; cyc++) begin
      sw_valid_i = 0; byte_done_i = 0;
      if (!busy_o) begin hang = 0; break; end
      if (tx_req_o) begin
        reqs++;
        sw_valid_i = 1; sw_byte_i = 8'h3C + 8'(17 * reqs + seed);
      end else if (tx_valid_o) begin
        if (tx_is_pec_o) begin pec_seen++; pec_val = tx_byte_o; end
        else crc = ref_crc(crc, tx_byte_o);
        byte_done_i = 1; ack_i = (nbyte != nack_at);
        nbyte++;
      end
      @(negedge clk);
    end
    sw_valid_i = 0; byte_done_i = 0;
    check({tag, " finished"}, hang, 0);
    check({tag, " request count"}, reqs, exp_req);
    check({"R5/R8 pec sent"}, pec_seen, exp_pec);
    if (exp_pec && pec_seen == 1) check("R7/R9 pec value", pec_val, crc);
    check("R8/R3 total bytes", nbyte, exp_req + (exp_pec ? 1 : 0));
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hang expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed = 0;
    #1;
    check("R1 busy", busy_o, 0);
    check("R1 req", tx_req_o, 0);
    check("R1 valid", tx_valid_o, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 pec flag", tx_is_pec_o, 0);
    for (int b = 0; b < 2; b++)
      for (int p = 0; p < 2; p++)
        for (int r = 0; r < 2; r++)
          for (int n = 0; n <= 4; n++)
            for (int k = 0; k < 4; k++) begin
              int na = (k == 3) ? ((b == 0) ? 5 : 99) : k;
              seed++;
              run(b[0], p[0], r[0], n, na, seed);
            end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule